// File: doc/BRIEF.md
# Prescaled Timer/Counter with Interrupt Mask

This block is the timing peripheral of a small 4-bit controller. A 4-bit up-counter that software can load advances on one of two sources. In timer mode the source is a 6-bit prescaler that divides the instruction clock enable by 64. In counter mode the source is each rising edge on an external pin. When the counter steps from 15 back to 0, it raises an overflow event and keeps counting.

An overflow event reaches a single mask flip-flop. If the flip-flop is clear, the event produces a one-cycle interrupt request and sets the flip-flop. While the flip-flop is set, further overflows are silent until software clears it again. Software can also set the flip-flop directly and can read its value.

A load of the counter also restarts the prescaler. This gives software an exact 64-clock interval to the next timer step.

Top module: `tmr_cnt_unit`

## Requirements
- R1: In timer mode the counter advances exactly once per 64 cycles with `clk_en` high; cycles with `clk_en` low do not advance the prescaler.
- R2: The counter increments modulo 16: after 15 it shows 0 and keeps counting upward.
- R3: In counter mode each 0-to-1 transition of `ext_pin` advances the counter once, visible on `cnt_q` after the third rising clock edge that samples the new pin level; a level held high counts only once.
- R4: `mode_wr` high loads `mode_val` into the mode flip-flop (0 = timer, 1 = counter). Prescaler overflows have no effect in counter mode, and pin edges have no effect in timer mode.
- R5: `load_stb` high writes `load_val` into the counter at the next edge and clears the prescaler, so the next timer step comes on the 64th enabled cycle after the load.
- R6: When a load and a count event occur in the same cycle, the load value is taken and the count event is lost.
- R7: An overflow while the mask is 0 makes `irq` high for exactly one cycle, the first cycle in which `cnt_q` shows 0, and sets `mask_q` to 1 in that same cycle.
- R8: An overflow while the mask is 1 leaves `irq` low and `mask_q` at 1.
- R9: `mask_clr` forces the mask to 0 and `mask_set` forces it to 1, with clear taking precedence. `mask_q` shows the mask. A software write in the cycle of an overflow overrides the overflow, and no `irq` is issued.
- R10: While `rst_n` is low, the counter, prescaler, mode and mask are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Instruction clock enable, drives the prescaler |
| load_stb | input | 1 | Load strobe for the counter |
| load_val | input | 4 | Value to load into the counter |
| mode_wr | input | 1 | Write strobe for the mode flip-flop |
| mode_val | input | 1 | Mode to write: 0 timer, 1 pin counter |
| mask_set | input | 1 | Set the interrupt mask |
| mask_clr | input | 1 | Clear the interrupt mask |
| ext_pin | input | 1 | Asynchronous external count pin |
| cnt_q | output | 4 | Current counter value |
| mask_q | output | 1 | Mask flip-flop value (test output) |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Some rules are checked on every cycle by the bound checker. These are: a load takes effect, the counter only holds or advances by one, `irq` is a single-cycle pulse that coincides with a 15-to-0 wrap and a newly set mask, and a mask clear always wins. Other behaviours depend on long intervals and on how events line up, so only the bench's scenarios can show them. These are the exact 64-cycle prescaler spacing, gapped enables, the three-edge latency of the pin path, a load landing on a prescaler overflow, silenced overflows while the mask is set, and a software mask write in the overflow cycle. For these the bench compares against a behavioural reference model on every clock and adds directed checks.

// File: rtl/tmr_pkg.sv
// Shared widths and types for the prescaled timer/counter.
// Assumes: the widths below fit a 4-bit controller peripheral.
package tmr_pkg;
    localparam int PRE_W      = 6;   // prescaler width, divides by 2**PRE_W
    localparam int CNT_W      = 4;   // main counter width
    localparam int SYNC_DEPTH = 2;   // synchronizer stages on the pin

    typedef enum logic {
        SRC_PRESCALE = 1'b0,         // counter stepped by prescaler overflow
        SRC_PIN      = 1'b1          // counter stepped by pin rising edges
    } cnt_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running divider. It advances on every enabled cycle and flags the
// cycle in which it rolls over from all-ones to zero.
// Assumes: a clear has priority over counting, and it masks the rollover
//          flag in the same cycle.
module tmr_prescaler #(
    parameter int WIDTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clear,
    output logic roll
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] div_q;

    // Rollover is reported only for an enabled cycle that is not cleared.
    always_comb begin
        roll = tick_en && (div_q == TOP) && !clear;
    end

    // Division state: reset or clear to zero, else step when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear) begin
            div_q <= '0;
        end else if (tick_en) begin
            div_q <= div_q + WIDTH'(1);
        end
    end
endmodule

// File: rtl/tmr_edge_sync.sv
// Brings an asynchronous pin into the clock domain through a chain of
// flops, then produces a one-cycle pulse for each 0-to-1 transition.
// Assumes: pin pulses are wider than one clock period.
module tmr_edge_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_pls
);
    logic [DEPTH-1:0] stage_q;
    logic             last_q;

    // First synchronizer stage captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= 1'b0;
        end else begin
            stage_q[0] <= pin_async;
        end
    end

    // Remaining stages repeat the same shift structure.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= 1'b0;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    // History flop of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= stage_q[DEPTH-1];
        end
    end

    // A rising edge is seen as old level low, new level high.
    always_comb begin
        rise_pls = stage_q[DEPTH-1] && !last_q;
    end
endmodule

// File: rtl/tmr_counter.sv
// Loadable wrapping up-counter. It reports a wrap in the cycle whose step
// takes it from all-ones to zero.
// Assumes: load has priority over step; a step lost to a load is not
//          reported as a wrap.
module tmr_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             step,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] val_q;

    // Wrap flag: a genuine step out of the top value.
    always_comb begin
        wrap = step && !load && (val_q == TOP);
    end

    // Counter state: reset, load or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load) begin
            val_q <= load_data;
        end else if (step) begin
            val_q <= val_q + WIDTH'(1);
        end
    end

    // Expose the registered value.
    always_comb begin
        value = val_q;
    end
endmodule

// File: rtl/tmr_irq_mask.sv
// Single mask flip-flop that both latches an interrupt and blocks further
// ones. It also issues a registered one-cycle request pulse.
// Assumes: software writes win over a wrap in the same cycle, and clear
//          wins over set.
module tmr_irq_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic sw_set,
    input  logic sw_clr,
    output logic mask,
    output logic req
);
    logic mask_q;
    logic req_q;
    logic sw_write;
    logic take_irq;

    // Decide whether this cycle's wrap turns into a request.
    always_comb begin
        sw_write = sw_set || sw_clr;
        take_irq = wrap && !mask_q && !sw_write;
    end

    // Mask flip-flop update with software priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (sw_clr) begin
            mask_q <= 1'b0;
        end else if (sw_set) begin
            mask_q <= 1'b1;
        end else if (wrap) begin
            mask_q <= 1'b1;
        end
    end

    // Request pulse registered alongside the mask transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= take_irq;
        end
    end

    // Drive outputs from state.
    always_comb begin
        mask = mask_q;
        req  = req_q;
    end
endmodule

// File: rtl/tmr_cnt_unit.sv
// Top of the timer/counter. It joins the prescaler, the pin edge detector,
// the loadable counter and the interrupt mask, and holds the mode flip-flop
// that selects the counter's step source.
// Assumes: all inputs except ext_pin are synchronous to clk.
module tmr_cnt_unit
    import tmr_pkg::*;
#(
    parameter int PRE_BITS   = PRE_W,
    parameter int CNT_BITS   = CNT_W,
    parameter int SYNC_STAGE = SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                load_stb,
    input  logic [CNT_BITS-1:0] load_val,
    input  logic                mode_wr,
    input  logic                mode_val,
    input  logic                mask_set,
    input  logic                mask_clr,
    input  logic                ext_pin,
    output logic [CNT_BITS-1:0] cnt_q,
    output logic                mask_q,
    output logic                irq
);
    cnt_src_e src_q;
    logic     pre_roll;
    logic     pin_rise;
    logic     cnt_step;
    logic     cnt_wrap;

    // Mode flip-flop: chooses which event steps the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_PRESCALE;
        end else if (mode_wr) begin
            src_q <= cnt_src_e'(mode_val);
        end
    end

    // Step source selection by the current mode.
    always_comb begin
        cnt_step = (src_q == SRC_PIN) ? pin_rise : pre_roll;
    end

    tmr_prescaler #(
        .WIDTH   (PRE_BITS)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (clk_en),
        .clear   (load_stb),
        .roll    (pre_roll)
    );

    tmr_edge_sync #(
        .DEPTH     (SYNC_STAGE)
    ) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .rise_pls  (pin_rise)
    );

    tmr_counter #(
        .WIDTH     (CNT_BITS)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_stb),
        .load_data (load_val),
        .step      (cnt_step),
        .value     (cnt_q),
        .wrap      (cnt_wrap)
    );

    tmr_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (cnt_wrap),
        .sw_set (mask_set),
        .sw_clr (mask_clr),
        .mask   (mask_q),
        .req    (irq)
    );
endmodule

// File: rtl/tmr_cnt_checker.sv
// Cycle-level rules of the timer/counter, observed at its ports.
// Assumes: bound to every instance of tmr_cnt_unit.
module tmr_cnt_checker #(
    parameter int CNT_BITS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load_stb,
    input logic [CNT_BITS-1:0] load_val,
    input logic                mask_set,
    input logic                mask_clr,
    input logic [CNT_BITS-1:0] cnt_q,
    input logic                mask_q,
    input logic                irq
);
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (cnt_q == $past(load_val)));                        // R6

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> ((cnt_q == $past(cnt_q)) ||
                       (cnt_q == CNT_BITS'($past(cnt_q) + CNT_BITS'(1))))); // R2

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                   // R7

    AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt_q == '0) && ($past(cnt_q) == {CNT_BITS{1'b1}}));    // R7

    AST_IRQ_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mask_q);                                                 // R7

    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(mask_q));                                         // R8

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr |=> !mask_q && !irq);                                   // R9

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !mask_clr) |=> mask_q && !irq);                     // R9
endmodule

bind tmr_cnt_unit tmr_cnt_checker #(
    .CNT_BITS (CNT_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_stb (load_stb),
    .load_val (load_val),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .cnt_q    (cnt_q),
    .mask_q   (mask_q),
    .irq      (irq)
);

// File: tb/test_tmr_cnt_unit.sv
`timescale 1ns/1ps
module test_tmr_cnt_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       load_stb = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic       mode_wr = 1'b0;
    logic       mode_val = 1'b0;
    logic       mask_set = 1'b0;
    logic       mask_clr = 1'b0;
    logic       ext_pin = 1'b0;
    logic [3:0] cnt_q;
    logic       mask_q;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tmr_cnt_unit i_tmr_cnt_unit (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load_stb(load_stb),
        .load_val(load_val), .mode_wr(mode_wr), .mode_val(mode_val),
        .mask_set(mask_set), .mask_clr(mask_clr), .ext_pin(ext_pin),
        .cnt_q(cnt_q), .mask_q(mask_q), .irq(irq)
    );

    // Behavioural reference model, updated on each rising edge.
    int m_pre = 0, m_cnt = 0, m_mode = 0, m_mask = 0, m_irq = 0;
    int pin_hist[$] = '{0, 0, 0};

    always @(posedge clk) begin
        int rise, pre_ev, ev, wrapped, n_pre, n_cnt, n_mask;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_mode = 0; m_mask = 0; m_irq = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            rise    = (pin_hist[1] == 1 && pin_hist[2] == 0) ? 1 : 0;
            pre_ev  = (clk_en && m_pre == 63) ? 1 : 0;
            ev      = m_mode ? rise : pre_ev;
            wrapped = 0;
            n_pre   = m_pre;
            n_cnt   = m_cnt;
            if (load_stb) begin
                n_pre = 0;
                n_cnt = load_val;
            end else begin
                if (clk_en) n_pre = (m_pre + 1) % 64;
                if (ev) begin
                    wrapped = (m_cnt == 15) ? 1 : 0;
                    n_cnt = (m_cnt + 1) % 16;
                end
            end
            m_irq = (wrapped && !m_mask && !mask_set && !mask_clr) ? 1 : 0;
            if (mask_clr) n_mask = 0;
            else if (mask_set) n_mask = 1;
            else if (wrapped) n_mask = 1;
            else n_mask = m_mask;
            if (mode_wr) m_mode = mode_val;
            m_pre = n_pre; m_cnt = n_cnt; m_mask = n_mask;
            pin_hist.push_front(ext_pin);
            void'(pin_hist.pop_back());
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R2", "model cnt_q", cnt_q, m_cnt);
            chk("R9", "model mask_q", mask_q, m_mask);
            chk("R7", "model irq", irq, m_irq);
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(int v);
        load_val = 4'(v); load_stb = 1'b1; cyc(); load_stb = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R10", "reset cnt_q", cnt_q, 0);
        chk("R10", "reset mask_q", mask_q, 0);
        chk("R10", "reset irq", irq, 0);
        rst_n = 1'b1;
        clk_en = 1'b1;

        // R5 and R1: step comes on the 64th enabled cycle after a load.
        do_load(14);
        chk("R5", "after load", cnt_q, 14);
        cyc(63); chk("R5", "63 after load", cnt_q, 14);
        cyc(1);  chk("R1", "64 after load", cnt_q, 15);
        cyc(63); chk("R1", "before wrap", cnt_q, 15);
        cyc(1);
        chk("R2", "wrap to zero", cnt_q, 0);
        chk("R7", "irq on wrap", irq, 1);
        chk("R7", "mask set by wrap", mask_q, 1);
        cyc(1);  chk("R7", "irq single cycle", irq, 0);
        cyc(64); chk("R2", "counts on after wrap", cnt_q, 1);
        cyc(959);
        chk("R8", "second wrap cnt", cnt_q, 0);
        chk("R8", "no irq while masked", irq, 0);
        chk("R8", "mask stays", mask_q, 1);

        // R9: software mask control.
        mask_clr = 1'b1; cyc(); mask_clr = 1'b0;
        chk("R9", "mask cleared", mask_q, 0);
        mask_set = 1'b1; mask_clr = 1'b1; cyc(); mask_set = 1'b0; mask_clr = 1'b0;
        chk("R9", "clear beats set", mask_q, 0);
        mask_set = 1'b1; cyc(); mask_set = 1'b0;
        chk("R9", "mask set", mask_q, 1);
        mask_clr = 1'b1; cyc(); mask_clr = 1'b0;

        // R6: load on the prescaler overflow cycle.
        do_load(5);
        cyc(63);
        load_val = 4'd9; load_stb = 1'b1; cyc(); load_stb = 1'b0;
        chk("R6", "load beats step", cnt_q, 9);
        cyc(63); chk("R5", "prescaler restarted", cnt_q, 9);
        cyc(1);  chk("R5", "step after restart", cnt_q, 10);

        // R1: gapped enable, 64 enabled cycles over 128 clocks.
        do_load(0);
        for (int i = 0; i < 128; i++) begin
            clk_en = (i % 2 == 0);
            cyc();
            if (i == 125) chk("R1", "gapped before step", cnt_q, 0);
        end
        chk("R1", "gapped one step", cnt_q, 1);
        clk_en = 1'b1;

        // R4 and R3: pin counting mode.
        mode_val = 1'b1; mode_wr = 1'b1; load_val = 4'd14; load_stb = 1'b1;
        cyc(); mode_wr = 1'b0; load_stb = 1'b0;
        cyc(200); chk("R4", "prescaler ignored in pin mode", cnt_q, 14);
        ext_pin = 1'b1;
        cyc(2); chk("R3", "pin latency two edges", cnt_q, 14);
        cyc(1); chk("R3", "pin counted at third edge", cnt_q, 15);
        cyc(10); chk("R3", "held level counts once", cnt_q, 15);
        ext_pin = 1'b0; cyc(5);
        ext_pin = 1'b1; cyc(3);
        chk("R7", "pin wrap", cnt_q, 0);
        chk("R7", "pin wrap irq", irq, 1);
        chk("R7", "pin wrap mask", mask_q, 1);
        ext_pin = 1'b0; cyc(4);

        // R9: software set in the overflow cycle suppresses irq.
        mask_clr = 1'b1; cyc(); mask_clr = 1'b0;
        do_load(15);
        ext_pin = 1'b1; cyc(2);
        mask_set = 1'b1; cyc(); mask_set = 1'b0;
        chk("R9", "write-cycle wrap cnt", cnt_q, 0);
        chk("R9", "software write wins, no irq", irq, 0);
        chk("R9", "mask from software", mask_q, 1);
        ext_pin = 1'b0; cyc(4);

        // R4: pin edges ignored in timer mode.
        mode_val = 1'b0; mode_wr = 1'b1; clk_en = 1'b0; cyc(); mode_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4);
        end
        chk("R4", "pin ignored in timer mode", cnt_q, 0);

        // R10: reset mid-run.
        rst_n = 1'b0; cyc(2);
        chk("R10", "reset clears counter", cnt_q, 0);
        chk("R10", "reset clears mask", mask_q, 0);
        rst_n = 1'b1; cyc(2);
        finish_run();
    end
endmodule